// File: doc/BRIEF.md
# Floating-Point Reservation Station Array

This block parks arithmetic operations after they leave in-order issue and holds them until their source operands exist. There are two classes of station: three for add and subtract, two for multiply and divide. Each issued operation carries, per operand, either a value or the tag of the station that will produce that value. Stations snoop a single result bus. When a broadcast tag matches one a station is waiting on, the station copies the value in.

Once both operands are present, a station competes for its class's execution unit. The oldest ready station wins. The units are fixed-latency models that compute integer stand-ins for the arithmetic. A finished unit drives the result bus with its station's tag and the value, and that station becomes free at the end of the broadcast cycle. Issue stays in program order, but execution can start out of order within a class.

Top module: `rsv_station_array`

## Requirements
- R1: After reset no station is occupied, `iss_ready` is high for every opcode, `iss_tag` shows the first station of the opcode's class, and `cdb_valid` is low.
- R2: Opcodes are encoded as 0 add, 1 subtract, 2 multiply, 3 divide. Add and subtract go to stations tagged 1 to 3. Multiply and divide go to stations tagged 4 and 5. The lowest-numbered free station of the class is taken, and `iss_tag` shows its tag before the issuing edge.
- R3: `iss_ready` is low when the class of `iss_op` has no free station. An `iss_valid` in that cycle allocates nothing and never produces a result.
- R4: An operand tag of 0 means the value given at issue is used. A nonzero tag makes the station wait for a broadcast with that tag and then take the broadcast value for that operand.
- R5: An operation starts only with both operands present. An operation whose operands are ready at issue, and whose unit and bus are free, starts on the edge after issue.
- R6: Execution takes 2 cycles for add and subtract, 10 for multiply and 40 for divide. The result appears on the bus after the edge that falls latency+1 edges after the starting edge's predecessor, which is latency+1 edges after issue in the uncontended case.
- R7: Results are 16-bit: a+b, a-b, and the low half of a*b, all modulo 2^16. Divide gives the unsigned quotient a/b, or all ones when b is zero.
- R8: When several stations of one class are ready together, the one issued earliest starts first, whatever its station number.
- R9: At most one result is broadcast per cycle. If both units finish together, the multiply/divide unit drives the bus and the add unit broadcasts in the next cycle.
- R10: A station is freed at the end of its broadcast cycle and can be issued to on the following edge.
- R11: An issue whose operand tag matches the broadcast in that same cycle captures the broadcast value and does not wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 2 | Opcode: 0 add, 1 sub, 2 mul, 3 div |
| iss_vj | input | 16 | First operand value |
| iss_qj | input | 3 | First operand producer tag, 0 if value given |
| iss_vk | input | 16 | Second operand value |
| iss_qk | input | 3 | Second operand producer tag, 0 if value given |
| iss_ready | output | 1 | A station of the opcode's class is free |
| iss_tag | output | 3 | Tag of the station this issue would occupy |
| cdb_valid | output | 1 | Result broadcast valid |
| cdb_tag | output | 3 | Tag of the station whose result is broadcast |
| cdb_value | output | 16 | Broadcast result |

## Verification
An operation issued with both operands ready is due on the bus latency+1 edges after its issue edge: 3 for add and subtract, 11 for multiply, 41 for divide. A dependent add is due 4 edges after its producer's broadcast, and a loser of bus arbitration is due one edge late. The bench records every broadcast together with the edge count after which it became visible. Each result's edge is compared with the edge worked out from the issue edges, and the bench also checks that no unexpected broadcast appeared. Stall and tag checks sample the combinational issue outputs one time step after the inputs settle, away from the clock edge.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_MUL = 2'd2,
      OP_DIV = 2'd3
   } fp_op_e;
endpackage

// File: rtl/rsa_station.sv
module rsa_station #(
   parameter int DATA_W = 16,
   parameter int TAG_W  = 3,
   parameter int MY_TAG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic              alloc_alt,
   input  logic [DATA_W-1:0] alloc_vj,
   input  logic [TAG_W-1:0]  alloc_qj,
   input  logic [DATA_W-1:0] alloc_vk,
   input  logic [TAG_W-1:0]  alloc_qk,
   input  logic              start,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_value,
   output logic              busy,
   output logic              ready,
   output logic              alt,
   output logic [DATA_W-1:0] vj,
   output logic [DATA_W-1:0] vk
);
   localparam logic [TAG_W-1:0] SELF = TAG_W'(MY_TAG);

   logic [TAG_W-1:0] qj, qk;
   logic             started;
   logic             own_bcast;

   assign own_bcast = cdb_valid && (cdb_tag == SELF);
   assign ready     = busy && !started && (qj == '0) && (qk == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         started <= 1'b0;
         alt     <= 1'b0;
         qj      <= '0;
         qk      <= '0;
         vj      <= '0;
         vk      <= '0;
      end else if (alloc) begin
         busy    <= 1'b1;
         started <= 1'b0;
         alt     <= alloc_alt;
         if ((alloc_qj != '0) && cdb_valid && (cdb_tag == alloc_qj)) begin
            vj <= cdb_value;
            qj <= '0;
         end else begin
            vj <= alloc_vj;
            qj <= alloc_qj;
         end
         if ((alloc_qk != '0) && cdb_valid && (cdb_tag == alloc_qk)) begin
            vk <= cdb_value;
            qk <= '0;
         end else begin
            vk <= alloc_vk;
            qk <= alloc_qk;
         end
      end else if (busy) begin
         if (start) started <= 1'b1;
         if ((qj != '0) && cdb_valid && (cdb_tag == qj)) begin
            vj <= cdb_value;
            qj <= '0;
         end
         if ((qk != '0) && cdb_valid && (cdb_tag == qk)) begin
            vk <= cdb_value;
            qk <= '0;
         end
         if (own_bcast) begin
            busy    <= 1'b0;
            started <= 1'b0;
         end
      end
   end

   p_alloc_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !busy);
   p_start_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> ready);
   p_bcast_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
      own_bcast |-> (busy && started));
   p_free_after_bcast_r10: assert property (@(posedge clk) disable iff (!rst_n)
      own_bcast |=> !busy);
endmodule

// File: rtl/rsa_age_pick.sv
module rsa_age_pick #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] alloc,
   input  logic [N-1:0] busy,
   input  logic [N-1:0] ready,
   output logic [N-1:0] free_pick,
   output logic         any_free,
   output logic [N-1:0] oldest
);
   // older_q[i][j] set: entry i was issued before entry j
   logic [N-1:0] older_q [N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) older_q[i] <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
               if (i == j)        older_q[i][j] <= 1'b0;
               else if (alloc[i]) older_q[i][j] <= 1'b0;
               else if (alloc[j]) older_q[i][j] <= busy[i];
            end
         end
      end
   end

   always_comb begin
      free_pick = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            free_pick    = '0;
            free_pick[i] = 1'b1;
         end
      end
   end
   assign any_free = |(~busy);

   always_comb begin
      for (int i = 0; i < N; i++) begin
         oldest[i] = ready[i];
         for (int j = 0; j < N; j++) begin
            if (ready[j] && older_q[j][i]) oldest[i] = 1'b0;
         end
      end
   end

   p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(oldest));
   p_grant_exists_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|ready) |-> (|oldest));
endmodule

// File: rtl/rsa_unit.sv
module rsa_unit #(
   parameter int DATA_W    = 16,
   parameter int TAG_W     = 3,
   parameter bit IS_MULDIV = 1'b0,
   parameter int LAT_A     = 2,
   parameter int LAT_B     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              go_alt,
   input  logic [DATA_W-1:0] go_a,
   input  logic [DATA_W-1:0] go_b,
   input  logic [TAG_W-1:0]  go_tag,
   input  logic              grant,
   output logic              can_take,
   output logic              done,
   output logic [TAG_W-1:0]  res_tag,
   output logic [DATA_W-1:0] res_val
);
   localparam int LMAX  = (LAT_A > LAT_B) ? LAT_A : LAT_B;
   localparam int CNT_W = $clog2(LMAX + 1);

   if (LAT_A < 1 || LAT_B < 1) begin : g_bad_lat
      $error("unit latency must be at least one cycle");
   end

   logic              active;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] calc;

   if (IS_MULDIV) begin : g_muldiv
      always_comb begin
         if (go_alt) calc = (go_b == '0) ? '1 : go_a / go_b;
         else        calc = go_a * go_b;
      end
   end else begin : g_addsub
      always_comb calc = go_alt ? go_a - go_b : go_a + go_b;
   end

   assign can_take = !active || (done && grant);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         done    <= 1'b0;
         cnt     <= '0;
         res_tag <= '0;
         res_val <= '0;
      end else begin
         if (done && grant) begin
            active <= 1'b0;
            done   <= 1'b0;
         end
         if (go) begin
            active  <= 1'b1;
            done    <= 1'b0;
            cnt     <= go_alt ? CNT_W'(LAT_B) : CNT_W'(LAT_A);
            res_tag <= go_tag;
            res_val <= calc;
         end else if (active && !done) begin
            if (cnt == CNT_W'(1)) done <= 1'b1;
            else                  cnt  <= cnt - 1'b1;
         end
      end
   end

   p_go_accepted_r5: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> can_take);
   p_grant_has_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> done);
   p_hold_until_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !grant) |=> (done && $stable(res_val) && $stable(res_tag)));
endmodule

// File: rtl/rsv_station_array.sv
module rsv_station_array #(
   parameter int DATA_W  = 16,
   parameter int N_ADD   = 3,
   parameter int N_MUL   = 2,
   parameter int ADD_LAT = 2,
   parameter int MUL_LAT = 10,
   parameter int DIV_LAT = 40,
   localparam int N_ST   = N_ADD + N_MUL,
   localparam int TAG_W  = $clog2(N_ST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [1:0]        iss_op,
   input  logic [DATA_W-1:0] iss_vj,
   input  logic [TAG_W-1:0]  iss_qj,
   input  logic [DATA_W-1:0] iss_vk,
   input  logic [TAG_W-1:0]  iss_qk,
   output logic              iss_ready,
   output logic [TAG_W-1:0]  iss_tag,
   output logic              cdb_valid,
   output logic [TAG_W-1:0]  cdb_tag,
   output logic [DATA_W-1:0] cdb_value
);
   import rsa_pkg::*;

   if (N_ADD < 1 || N_MUL < 1) begin : g_bad_count
      $error("each station class needs at least one entry");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("data width too small");
   end

   fp_op_e op_in;
   logic   is_md, is_alt;
   assign op_in  = fp_op_e'(iss_op);
   assign is_md  = (op_in == OP_MUL) || (op_in == OP_DIV);
   assign is_alt = (op_in == OP_SUB) || (op_in == OP_DIV);

   logic [N_ST-1:0]   st_busy, st_ready, st_start, st_alloc, st_pick, st_alt;
   logic [DATA_W-1:0] st_vj [N_ST];
   logic [DATA_W-1:0] st_vk [N_ST];
   logic [1:0]        cls_free, u_take, u_done, u_grant;
   logic [TAG_W-1:0]  u_tag [2];
   logic [DATA_W-1:0] u_val [2];

   // fixed bus priority: multiply/divide unit ahead of add unit
   assign u_grant[1] = u_done[1];
   assign u_grant[0] = u_done[0] && !u_done[1];
   assign cdb_valid  = |u_done;
   assign cdb_tag    = u_done[1] ? u_tag[1] : u_tag[0];
   assign cdb_value  = u_done[1] ? u_val[1] : u_val[0];

   assign iss_ready = is_md ? cls_free[1] : cls_free[0];

   always_comb begin
      iss_tag = '0;
      for (int i = 0; i < N_ST; i++) begin
         if (st_pick[i] && ((i >= N_ADD) == is_md)) iss_tag = TAG_W'(i + 1);
      end
   end

   for (genvar c = 0; c < 2; c++) begin : g_cls
      localparam int NC   = (c == 0) ? N_ADD : N_MUL;
      localparam int BASE = (c == 0) ? 0 : N_ADD;

      logic [NC-1:0]     pick, oldest, alloc_c;
      logic              any_free, go, g_alt;
      logic [DATA_W-1:0] g_a, g_b;
      logic [TAG_W-1:0]  g_tag;
      logic              want;

      assign want    = (c == 1) ? is_md : !is_md;
      assign alloc_c = pick & {NC{iss_valid && want}};
      assign st_alloc[BASE +: NC] = alloc_c;
      assign st_pick[BASE +: NC]  = pick;
      assign cls_free[c]          = any_free;

      rsa_age_pick #(.N(NC)) u_age (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc     (alloc_c),
         .busy      (st_busy[BASE +: NC]),
         .ready     (st_ready[BASE +: NC]),
         .free_pick (pick),
         .any_free  (any_free),
         .oldest    (oldest)
      );

      for (genvar i = 0; i < NC; i++) begin : g_st
         rsa_station #(.DATA_W(DATA_W), .TAG_W(TAG_W), .MY_TAG(BASE + i + 1)) u_st (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc_c[i]),
            .alloc_alt (is_alt),
            .alloc_vj  (iss_vj),
            .alloc_qj  (iss_qj),
            .alloc_vk  (iss_vk),
            .alloc_qk  (iss_qk),
            .start     (st_start[BASE + i]),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_value (cdb_value),
            .busy      (st_busy[BASE + i]),
            .ready     (st_ready[BASE + i]),
            .alt       (st_alt[BASE + i]),
            .vj        (st_vj[BASE + i]),
            .vk        (st_vk[BASE + i])
         );
      end

      always_comb begin
         g_alt = 1'b0;
         g_a   = '0;
         g_b   = '0;
         g_tag = '0;
         for (int i = 0; i < NC; i++) begin
            if (oldest[i]) begin
               g_alt = st_alt[BASE + i];
               g_a   = st_vj[BASE + i];
               g_b   = st_vk[BASE + i];
               g_tag = TAG_W'(BASE + i + 1);
            end
         end
      end

      assign go = u_take[c] && (|oldest);
      assign st_start[BASE +: NC] = oldest & {NC{go}};

      rsa_unit #(
         .DATA_W    (DATA_W),
         .TAG_W     (TAG_W),
         .IS_MULDIV (c == 1),
         .LAT_A     ((c == 1) ? MUL_LAT : ADD_LAT),
         .LAT_B     ((c == 1) ? DIV_LAT : ADD_LAT)
      ) u_fu (
         .clk      (clk),
         .rst_n    (rst_n),
         .go       (go),
         .go_alt   (g_alt),
         .go_a     (g_a),
         .go_b     (g_b),
         .go_tag   (g_tag),
         .grant    (u_grant[c]),
         .can_take (u_take[c]),
         .done     (u_done[c]),
         .res_tag  (u_tag[c]),
         .res_val  (u_val[c])
      );
   end

   p_stall_no_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_ready) |-> (st_alloc == '0));
   p_issue_allocates_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready) |=> (st_busy != '0));
   p_loser_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (u_done[1] && u_done[0]) |=> u_done[0]);
endmodule

// File: tb/tb_rsv_station_array.sv
module tb_rsv_station_array;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        iss_valid;
   logic [1:0]  iss_op;
   logic [15:0] iss_vj, iss_vk;
   logic [2:0]  iss_qj, iss_qk;
   logic        iss_ready;
   logic [2:0]  iss_tag;
   logic        cdb_valid;
   logic [2:0]  cdb_tag;
   logic [15:0] cdb_value;

   always #5 clk = ~clk;

   rsv_station_array dut (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
      .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
      .iss_ready(iss_ready), .iss_tag(iss_tag), .cdb_valid(cdb_valid),
      .cdb_tag(cdb_tag), .cdb_value(cdb_value)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int          lg_cyc [128];
   logic [2:0]  lg_tag [128];
   logic [15:0] lg_val [128];
   int          n_log = 0;

   always @(posedge clk) begin
      #2;
      if (rst_n && cdb_valid && n_log < 128) begin
         lg_cyc[n_log] = cyc;
         lg_tag[n_log] = cdb_tag;
         lg_val[n_log] = cdb_value;
         n_log++;
      end
   end

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int when_seen(input int from, input logic [2:0] t, input logic [15:0] v);
      for (int i = from; i < n_log; i++)
         if (lg_tag[i] == t && lg_val[i] == v) return lg_cyc[i];
      return -1;
   endfunction

   task automatic issue(input logic [1:0] op, input logic [15:0] a, input logic [2:0] qa,
                        input logic [15:0] b, input logic [2:0] qb,
                        output int e, output logic [2:0] tg);
      iss_valid = 1'b1; iss_op = op; iss_vj = a; iss_qj = qa; iss_vk = b; iss_qk = qb;
      #1 tg = iss_tag;
      @(negedge clk);
      e = cyc;
      iss_valid = 1'b0; iss_vj = 16'hDEAD; iss_vk = 16'hBEEF;
   endtask

   task automatic wait_to(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   // op[49:48] a[47:32] b[31:16] expected[15:0]
   localparam logic [49:0] VEC [8] = '{
      {2'd0, 16'd5,     16'd7,   16'd12},
      {2'd1, 16'd10,    16'd3,   16'd7},
      {2'd1, 16'd3,     16'd10,  16'hFFF9},
      {2'd0, 16'hFFFF,  16'd2,   16'd1},
      {2'd2, 16'd300,   16'd300, 16'd24464},
      {2'd2, 16'd7,     16'd9,   16'd63},
      {2'd3, 16'd100,   16'd7,   16'd14},
      {2'd3, 16'd5,     16'd0,   16'hFFFF}
   };

   initial begin
      #1500000;
      if (!done_flag) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int e, e2, base, lat;
      logic [2:0] tg;
      rst_n = 1'b0; iss_valid = 1'b0; iss_op = 2'd0;
      iss_vj = '0; iss_vk = '0; iss_qj = '0; iss_qk = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      iss_op = 2'd0; #1;
      chk(iss_ready == 1'b1, "R1 add ready", iss_ready, 1);
      chk(iss_tag == 3'd1, "R1 add tag", iss_tag, 1);
      chk(cdb_valid == 1'b0, "R1 bus idle", cdb_valid, 0);
      iss_op = 2'd3; #1;
      chk(iss_ready == 1'b1, "R1 div ready", iss_ready, 1);
      chk(iss_tag == 3'd4, "R1 div tag", iss_tag, 4);
      @(negedge clk);

      // vector table: R2 R6 R7
      for (int v = 0; v < 8; v++) begin
         logic [1:0] op; logic [15:0] a, b, ex;
         op = VEC[v][49:48]; a = VEC[v][47:32]; b = VEC[v][31:16]; ex = VEC[v][15:0];
         lat = (op == 2'd3) ? 40 : (op == 2'd2) ? 10 : 2;
         base = n_log;
         issue(op, a, 3'd0, b, 3'd0, e, tg);
         chk(tg == (op[1] ? 3'd4 : 3'd1), "R2 issue tag", tg, op[1] ? 4 : 1);
         wait_to(e + lat + 3);
         chk(n_log == base + 1, "R7 one result", n_log - base, 1);
         chk(lg_cyc[base] == e + lat + 1, "R6 latency", lg_cyc[base] - e, lat + 1);
         chk(lg_tag[base] == (op[1] ? 3'd4 : 3'd1), "R2 bus tag", lg_tag[base], op[1] ? 4 : 1);
         chk(lg_val[base] == ex, "R7 value", lg_val[base], ex);
      end

      // R4 dependent wait on tag 4
      base = n_log;
      issue(2'd2, 16'd3, 3'd0, 16'd5, 3'd0, e, tg);
      issue(2'd0, 16'd0, 3'd4, 16'd7, 3'd0, e2, tg);
      wait_to(e + 18);
      chk(when_seen(base, 3'd4, 16'd15) == e + 11, "R4 producer", when_seen(base, 3'd4, 16'd15), e + 11);
      chk(when_seen(base, 3'd1, 16'd22) == e + 15, "R4 capture", when_seen(base, 3'd1, 16'd22), e + 15);
      chk(n_log == base + 2, "R5 no early start", n_log - base, 2);

      // R11 issue in the broadcast cycle
      base = n_log;
      issue(2'd2, 16'd6, 3'd0, 16'd2, 3'd0, e, tg);
      wait_to(e + 11);
      chk(cdb_valid && cdb_tag == 3'd4, "R11 broadcast now", cdb_tag, 4);
      issue(2'd0, 16'd0, 3'd4, 16'd1, 3'd0, e2, tg);
      wait_to(e + 18);
      chk(when_seen(base, 3'd1, 16'd13) == e + 15, "R11 bypass", when_seen(base, 3'd1, 16'd13), e + 15);

      // R3 R8 R10 stall, age order and reuse
      base = n_log;
      issue(2'd2, 16'd3, 3'd0, 16'd5, 3'd0, e, tg);
      issue(2'd0, 16'd1, 3'd0, 16'd1, 3'd0, e2, tg);
      issue(2'd0, 16'd0, 3'd4, 16'd100, 3'd0, e2, tg);
      chk(tg == 3'd2, "R2 second free", tg, 2);
      issue(2'd0, 16'd0, 3'd4, 16'd200, 3'd0, e2, tg);
      iss_valid = 1'b1; iss_op = 2'd0; iss_vj = 16'd50; iss_vk = 16'd50; iss_qj = 0; iss_qk = 0;
      #1 chk(iss_ready == 1'b0, "R3 full stall", iss_ready, 0);
      @(negedge clk);
      chk(iss_ready == 1'b0, "R10 busy while broadcasting", iss_ready, 0);
      iss_valid = 1'b0;
      @(negedge clk);
      issue(2'd0, 16'd0, 3'd4, 16'd1000, 3'd0, e2, tg);
      chk(tg == 3'd1, "R10 reuse freed", tg, 1);
      wait_to(e + 26);
      chk(when_seen(base, 3'd1, 16'd2) == e + 4, "R5 quick add", when_seen(base, 3'd1, 16'd2), e + 4);
      chk(when_seen(base, 3'd2, 16'd115) == e + 15, "R8 oldest first", when_seen(base, 3'd2, 16'd115), e + 15);
      chk(when_seen(base, 3'd3, 16'd215) == e + 18, "R8 second oldest", when_seen(base, 3'd3, 16'd215), e + 18);
      chk(when_seen(base, 3'd1, 16'd1015) == e + 21, "R8 youngest last", when_seen(base, 3'd1, 16'd1015), e + 21);
      chk(n_log == base + 5, "R3 stalled issue dropped", n_log - base, 5);

      // R3 multiply class full
      base = n_log;
      issue(2'd3, 16'd40, 3'd0, 16'd2, 3'd0, e, tg);
      issue(2'd2, 16'd2, 3'd0, 16'd2, 3'd0, e2, tg);
      chk(tg == 3'd5, "R2 second mul station", tg, 5);
      iss_op = 2'd2; #1;
      chk(iss_ready == 1'b0, "R3 mul class full", iss_ready, 0);
      iss_op = 2'd0; #1;
      chk(iss_ready == 1'b1, "R3 add class free", iss_ready, 1);
      wait_to(e + 55);
      chk(when_seen(base, 3'd4, 16'd20) == e + 41, "R6 divide", when_seen(base, 3'd4, 16'd20), e + 41);
      chk(when_seen(base, 3'd5, 16'd4) == e + 52, "R5 waits for unit", when_seen(base, 3'd5, 16'd4), e + 52);

      // R9 bus conflict
      base = n_log;
      issue(2'd2, 16'd2, 3'd0, 16'd3, 3'd0, e, tg);
      wait_to(e + 7);
      issue(2'd0, 16'd4, 3'd0, 16'd5, 3'd0, e2, tg);
      wait_to(e + 15);
      chk(when_seen(base, 3'd4, 16'd6) == e + 11, "R9 mul wins", when_seen(base, 3'd4, 16'd6), e + 11);
      chk(when_seen(base, 3'd1, 16'd9) == e + 12, "R9 add next", when_seen(base, 3'd1, 16'd9), e + 12);

      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule